// File: doc/BRIEF.md
# Dark-Column Black Level Estimator

This block watches a sensor pixel stream, one pixel per cycle on which the valid strobe is high, and works out a black level for every image line. It averages the light-shielded reference columns at both ends of the line. The leading empty pixels are skipped, and so is the outermost column of each shielded group, because light leaks into those columns. The line format is empty pixels, then a leading shielded group, then the photosensitive columns, then a trailing shielded group. Every count in that format is a parameter.

A frame marker and a line marker let the block count rows. Lines in the shielded rows above and below the image are not fully dark, so they never update the level. Lines seen before the first frame marker are treated the same way. The new level is ready right after the last trailing reference sample, well before the next line's active pixels arrive. An optional clamp stage subtracts the level held when a pixel arrives from each active pixel, flooring the result at zero. The clamp output is registered one cycle behind the input. A mode input chooses whether the level comes from the leading group, the trailing group, or both.

Top module: `bl_dark_ref_est`

## Requirements
- R1: After reset, `black_level` is 0 and `lvl_valid`, `out_valid` and `out_active` are 0.
- R2: Column positions count only cycles with `pix_valid` high. The pixel that carries `pix_sol` is column 0, and idle cycles between pixels do not move the count.
- R3: Only columns 5..22 (18 leading samples) and columns A+25..A+41 (17 trailing samples) feed the estimate, where A is the number of active columns. The four empty columns 0..3, the outer shielded columns 4, 23, A+24 and A+42, and all active columns are excluded.
- R4: `avg_mode` 2'b01 gives floor(leading sum / 18) and 2'b10 gives floor(trailing sum / 17). Both 2'b00 and 2'b11 give floor((leading sum + trailing sum) / 35). The mode is sampled with the last trailing reference sample.
- R5: `black_level` takes its new value, and `lvl_valid` pulses for exactly one cycle, on the clock edge that follows the last trailing reference sample of a reference row. At no other time does `black_level` change.
- R6: Row 0 is the line that carries `pix_sof`. Rows below TOP_N and rows from TOP_N+ROWS_N onward, as well as lines before the first `pix_sof`, leave `black_level` unchanged.
- R7: A line cut short by a new `pix_sol` before its last trailing reference sample leaves `black_level` unchanged.
- R8: An active pixel (columns 24..A+23) leaves the block as max(pixel − `black_level`, 0). Here `black_level` is the value held in the cycle the pixel enters, and `out_active` is 1 for that pixel.
- R9: `out_valid` follows `pix_valid` one cycle later. Non-active pixels pass through unchanged with `out_active` at 0.
- R10: A reference group of full-scale pixels yields a full-scale level, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel strobe |
| pix_sol | input | 1 | First pixel of a line |
| pix_sof | input | 1 | First line of a frame (with `pix_sol`) |
| pix_data | input | PIX_W | Pixel value |
| avg_mode | input | 2 | Averaging source select |
| black_level | output | PIX_W | Current per-line black level |
| lvl_valid | output | 1 | One-cycle pulse on a level update |
| out_valid | output | 1 | Output pixel strobe |
| out_active | output | 1 | Output pixel is an active column |
| out_data | output | PIX_W | Clamped or passed pixel |

## Verification
Some properties are checked by the assertions on every cycle. The region decodes must never overlap. A level update may follow only a last trailing reference sample in a reference row. The level must stay put between updates. The output strobe must trail the input strobe by one cycle, and a clamped pixel must never exceed its input. Other behaviour can only be shown by the bench's scenarios against its own model. This covers the exact averages in each mode, the exclusion of the empty and outer columns, rows outside the image, truncated lines, idle gaps inside a line, and saturation of the clamp.

// File: rtl/bl_pkg.sv
`timescale 1ns/1ps
package bl_pkg;

  typedef enum logic [1:0] {
    AVG_BOTH  = 2'b00,
    AVG_LEAD  = 2'b01,
    AVG_TRAIL = 2'b10,
    AVG_BOTHX = 2'b11
  } avg_mode_e;

  // floor(sum / n) by multiplying with ceil(2^sh / n); exact while sum*n < 2^sh
  function automatic logic [63:0] scale_div(logic [31:0] sum, int n, int sh);
    logic [63:0] recip;
    recip = ((64'd1 << sh) + 64'(n) - 64'd1) / 64'(n);
    return (64'(sum) * recip) >> sh;
  endfunction

  // a - b floored at zero
  function automatic logic [31:0] sat_sub(logic [31:0] a, logic [31:0] b);
    return (a > b) ? (a - b) : 32'd0;
  endfunction

endpackage

// File: rtl/bl_colmap.sv
`timescale 1ns/1ps
module bl_colmap #(
  parameter int EMPTY_N = 4,
  parameter int LEAD_N  = 20,
  parameter int ACT_N   = 4033,
  parameter int TRAIL_N = 19,
  parameter int EDGE_N  = 1,
  parameter int TOP_N   = 17,
  parameter int ROWS_N  = 2688,
  parameter int BOT_N   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_valid,
  input  logic pix_sol,
  input  logic pix_sof,
  output logic lead_ref,
  output logic trail_ref,
  output logic trail_last,
  output logic act_col,
  output logic ref_row
);
  localparam int LINE_N = EMPTY_N + LEAD_N + ACT_N + TRAIL_N;
  localparam int ROW_N  = TOP_N + ROWS_N + BOT_N;
  localparam int COL_W  = $clog2(LINE_N + 1);
  localparam int ROW_W  = $clog2(ROW_N + 1);
  localparam logic [COL_W-1:0] C_LEAD_LO = COL_W'(EMPTY_N + EDGE_N);
  localparam logic [COL_W-1:0] C_LEAD_HI = COL_W'(EMPTY_N + LEAD_N - EDGE_N);
  localparam logic [COL_W-1:0] C_ACT_LO  = COL_W'(EMPTY_N + LEAD_N);
  localparam logic [COL_W-1:0] C_ACT_HI  = COL_W'(EMPTY_N + LEAD_N + ACT_N);
  localparam logic [COL_W-1:0] C_TR_LO   = COL_W'(EMPTY_N + LEAD_N + ACT_N + EDGE_N);
  localparam logic [COL_W-1:0] C_TR_LAST = COL_W'(LINE_N - EDGE_N - 1);
  localparam logic [COL_W-1:0] C_END     = COL_W'(LINE_N);
  localparam logic [ROW_W-1:0] R_LO      = ROW_W'(TOP_N);
  localparam logic [ROW_W-1:0] R_HI      = ROW_W'(TOP_N + ROWS_N);
  localparam logic [ROW_W-1:0] R_END     = ROW_W'(ROW_N);

  logic [COL_W-1:0] col_q, col_cur;
  logic [ROW_W-1:0] row_q, row_cur;

  assign col_cur = pix_sol ? '0 : col_q;
  always_comb begin
    row_cur = row_q;
    if (pix_sol) row_cur = pix_sof ? '0 : ((row_q == R_END) ? row_q : row_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= C_END;
      row_q <= R_END;
    end else if (pix_valid) begin
      col_q <= (col_cur == C_END) ? col_cur : col_cur + 1'b1;
      row_q <= row_cur;
    end
  end

  assign lead_ref   = (col_cur >= C_LEAD_LO) && (col_cur < C_LEAD_HI);
  assign act_col    = (col_cur >= C_ACT_LO)  && (col_cur < C_ACT_HI);
  assign trail_ref  = (col_cur >= C_TR_LO)   && (col_cur <= C_TR_LAST);
  assign trail_last = (col_cur == C_TR_LAST);
  assign ref_row    = (row_cur >= R_LO) && (row_cur < R_HI);
endmodule

// File: rtl/bl_accum.sv
`timescale 1ns/1ps
module bl_accum
  import bl_pkg::*;
#(
  parameter int PIX_W     = 12,
  parameter int LEAD_USE  = 18,
  parameter int TRAIL_USE = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sol,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             lead_ref,
  input  logic             trail_ref,
  input  logic             trail_last,
  input  logic             ref_row,
  input  logic [1:0]       avg_mode,
  output logic [PIX_W-1:0] level,
  output logic             level_stb
);
  localparam int BOTH_USE = LEAD_USE + TRAIL_USE;
  localparam int SUM_W    = PIX_W + $clog2(BOTH_USE + 1);
  localparam int DIV_SH   = SUM_W + $clog2(BOTH_USE + 1);

  logic [SUM_W-1:0] lead_sum, trail_sum, lead_add, trail_tot;
  logic [PIX_W-1:0] avg_lead, avg_trail, avg_both, avg_sel;
  logic             upd;

  assign lead_add  = lead_ref  ? SUM_W'(pix_data) : '0;
  assign trail_tot = trail_sum + (trail_ref ? SUM_W'(pix_data) : '0);

  assign avg_lead  = PIX_W'(scale_div(32'(lead_sum), LEAD_USE, DIV_SH));
  assign avg_trail = PIX_W'(scale_div(32'(trail_tot), TRAIL_USE, DIV_SH));
  assign avg_both  = PIX_W'(scale_div(32'(lead_sum) + 32'(trail_tot), BOTH_USE, DIV_SH));

  always_comb begin
    case (avg_mode_e'(avg_mode))
      AVG_LEAD:  avg_sel = avg_lead;
      AVG_TRAIL: avg_sel = avg_trail;
      default:   avg_sel = avg_both;
    endcase
  end

  assign upd = pix_valid && !pix_sol && trail_last && ref_row;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_sum  <= '0;
      trail_sum <= '0;
      level     <= '0;
      level_stb <= 1'b0;
    end else begin
      level_stb <= upd;
      if (upd) level <= avg_sel;
      if (pix_valid) begin
        lead_sum  <= pix_sol ? '0 : lead_sum + lead_add;
        trail_sum <= pix_sol ? '0 : trail_tot;
      end
    end
  end
endmodule

// File: rtl/bl_clamp.sv
`timescale 1ns/1ps
module bl_clamp
  import bl_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             act_col,
  input  logic [PIX_W-1:0] level,
  output logic             out_valid,
  output logic             out_active,
  output logic [PIX_W-1:0] out_data
);
  logic [PIX_W-1:0] proc;

  generate
    if (CLAMP_EN) begin : g_clamp
      assign proc = act_col ? PIX_W'(sat_sub(32'(pix_data), 32'(level))) : pix_data;
    end else begin : g_pass
      logic unused_lvl;
      assign unused_lvl = ^level;
      assign proc = pix_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_active <= 1'b0;
      out_data   <= '0;
    end else begin
      out_valid  <= pix_valid;
      out_active <= pix_valid && act_col;
      if (pix_valid) out_data <= proc;
    end
  end
endmodule

// File: rtl/bl_dark_ref_est.sv
`timescale 1ns/1ps
module bl_dark_ref_est #(
  parameter int PIX_W    = 12,
  parameter int EMPTY_N  = 4,
  parameter int LEAD_N   = 20,
  parameter int ACT_N    = 4033,
  parameter int TRAIL_N  = 19,
  parameter int EDGE_N   = 1,
  parameter int TOP_N    = 17,
  parameter int ROWS_N   = 2688,
  parameter int BOT_N    = 16,
  parameter bit CLAMP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  logic             pix_sol,
  input  logic             pix_sof,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [1:0]       avg_mode,
  output logic [PIX_W-1:0] black_level,
  output logic             lvl_valid,
  output logic             out_valid,
  output logic             out_active,
  output logic [PIX_W-1:0] out_data
);
  localparam int LEAD_USE  = LEAD_N - 2 * EDGE_N;
  localparam int TRAIL_USE = TRAIL_N - 2 * EDGE_N;

  logic lead_ref_w, trail_ref_w, trail_last_w, act_w, ref_row_w;

  bl_colmap #(
    .EMPTY_N(EMPTY_N), .LEAD_N(LEAD_N), .ACT_N(ACT_N), .TRAIL_N(TRAIL_N),
    .EDGE_N(EDGE_N), .TOP_N(TOP_N), .ROWS_N(ROWS_N), .BOT_N(BOT_N)
  ) u_colmap (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .lead_ref(lead_ref_w), .trail_ref(trail_ref_w),
    .trail_last(trail_last_w), .act_col(act_w), .ref_row(ref_row_w)
  );

  bl_accum #(
    .PIX_W(PIX_W), .LEAD_USE(LEAD_USE), .TRAIL_USE(TRAIL_USE)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
    .pix_data(pix_data), .lead_ref(lead_ref_w), .trail_ref(trail_ref_w),
    .trail_last(trail_last_w), .ref_row(ref_row_w), .avg_mode(avg_mode),
    .level(black_level), .level_stb(lvl_valid)
  );

  bl_clamp #(
    .PIX_W(PIX_W), .CLAMP_EN(CLAMP_EN)
  ) u_clamp (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .act_col(act_w), .level(black_level), .out_valid(out_valid),
    .out_active(out_active), .out_data(out_data)
  );
endmodule

// File: rtl/bl_dark_ref_chk.sv
`timescale 1ns/1ps
module bl_dark_ref_chk #(
  parameter int PIX_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_valid,
  input logic             pix_sol,
  input logic [PIX_W-1:0] pix_data,
  input logic [PIX_W-1:0] black_level,
  input logic             lvl_valid,
  input logic             out_valid,
  input logic             out_active,
  input logic [PIX_W-1:0] out_data,
  input logic             lead_ref_w,
  input logic             trail_ref_w,
  input logic             trail_last_w,
  input logic             act_w,
  input logic             ref_row_w
);
  a_r3_regions_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lead_ref_w, trail_ref_w, act_w}));

  a_r5_stb_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_sol && trail_last_w && ref_row_w) |=> lvl_valid);

  a_r5_stb_source: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> $past(pix_valid && trail_last_w));

  a_r6_stb_ref_row: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> $past(ref_row_w));

  a_r5_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_valid |-> $stable(black_level));

  a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(pix_valid));

  a_r8_clamp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_active) |-> (out_data <= $past(pix_data)));
endmodule

bind bl_dark_ref_est bl_dark_ref_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
  .pix_data(pix_data), .black_level(black_level), .lvl_valid(lvl_valid),
  .out_valid(out_valid), .out_active(out_active), .out_data(out_data),
  .lead_ref_w(lead_ref_w), .trail_ref_w(trail_ref_w),
  .trail_last_w(trail_last_w), .act_w(act_w), .ref_row_w(ref_row_w)
);

// File: tb/test_bl_dark_ref_est.sv
`timescale 1ns/1ps
module test_bl_dark_ref_est;
  localparam int PW = 12, EMP = 4, LDN = 20, ACT = 40, TRN = 19;
  localparam int TOP = 2, ROWS = 3, BOT = 2;
  localparam int LINE = EMP + LDN + ACT + TRN;
  localparam int LEAD_LO = EMP + 1, LEAD_HI = EMP + LDN - 1;
  localparam int ACT_LO = EMP + LDN, ACT_HI = ACT_LO + ACT;
  localparam int TR_LO = ACT_HI + 1, TR_HI = LINE - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_valid = 0, pix_sol = 0, pix_sof = 0;
  logic [PW-1:0] pix_data = '0;
  logic [1:0] avg_mode = 2'b00;
  logic [PW-1:0] black_level, out_data;
  logic lvl_valid, out_valid, out_active;

  always #10 clk = ~clk;

  bl_dark_ref_est #(.PIX_W(PW), .ACT_N(ACT), .TOP_N(TOP), .ROWS_N(ROWS), .BOT_N(BOT))
    i_bl_dark_ref_est (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
    .pix_sof(pix_sof), .pix_data(pix_data), .avg_mode(avg_mode),
    .black_level(black_level), .lvl_valid(lvl_valid), .out_valid(out_valid),
    .out_active(out_active), .out_data(out_data));

  int n_tests = 0, n_fail = 0;
  int lbuf [LINE];
  int exp_level = 0, col_m = 100000, row_m = 100000, ls = 0, ts = 0;
  bit pend = 0, pend_act = 0, pend_stb = 0;
  int pend_exp = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_avg(logic [1:0] m, int l, int t);
    if (m == 2'b01) return l / 18;
    if (m == 2'b10) return t / 17;
    return (l + t) / 35;
  endfunction

  task automatic drive(bit v, bit sol, bit sof, int d);
    bit is_ref;
    @(negedge clk);
    chk(lvl_valid == pend_stb, "R5 lvl_valid", int'(lvl_valid), int'(pend_stb));
    if (pend_stb) chk(black_level == PW'(exp_level), "R4 level", int'(black_level), exp_level);
    chk(out_valid == pend, "R9 out_valid", int'(out_valid), int'(pend));
    if (pend) begin
      chk(out_active == pend_act, pend_act ? "R8 out_active" : "R9 out_active",
          int'(out_active), int'(pend_act));
      chk(out_data == PW'(pend_exp), pend_act ? "R8 clamp" : "R9 pass",
          int'(out_data), pend_exp);
    end
    pix_valid = v; pix_sol = sol; pix_sof = sof; pix_data = PW'(d);
    pend = v; pend_stb = 0; pend_act = 0;
    if (v) begin
      if (sol) begin
        col_m = 0; ls = 0; ts = 0;
        if (sof) row_m = 0; else if (row_m < 100000) row_m++;
      end else if (col_m < 100000) col_m++;
      pend_act = (col_m >= ACT_LO) && (col_m < ACT_HI);
      pend_exp = pend_act ? ((d > exp_level) ? d - exp_level : 0) : d;
      if (col_m >= LEAD_LO && col_m < LEAD_HI) ls += d;
      if (col_m >= TR_LO && col_m < TR_HI) ts += d;
      is_ref = (row_m >= TOP) && (row_m < TOP + ROWS);
      if (col_m == TR_HI - 1 && is_ref) begin
        pend_stb = 1;
        exp_level = model_avg(avg_mode, ls, ts);
      end
    end
  endtask

  task automatic send_line(int len, bit sof, bit gaps);
    for (int c = 0; c < len; c++) begin
      if (gaps && ($urandom % 4 == 0)) drive(0, 0, 0, int'($urandom % 4096));
      drive(1, c == 0, sof && (c == 0), lbuf[c]);
    end
    drive(0, 0, 0, 0);
  endtask

  task automatic fill_rand(int maxv);
    for (int c = 0; c < LINE; c++) lbuf[c] = int'($urandom % maxv);
  endtask

  task automatic fill_dir(int lead_v, int trail_v, int junk);
    for (int c = 0; c < LINE; c++) begin
      if (c >= LEAD_LO && c < LEAD_HI) lbuf[c] = lead_v;
      else if (c >= TR_LO && c < TR_HI) lbuf[c] = trail_v;
      else if (c >= ACT_LO && c < ACT_HI) lbuf[c] = int'($urandom % 4096);
      else lbuf[c] = junk;
    end
  endtask

  task automatic hold_chk(string req, int saved);
    chk(black_level == PW'(saved), req, int'(black_level), saved);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int saved;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(black_level == 0, "R1 level", int'(black_level), 0);
    chk(out_valid == 0 && lvl_valid == 0 && out_active == 0, "R1 strobes",
        int'({out_valid, lvl_valid, out_active}), 0);
    rst_n = 1'b1;

    // R6: lines before any frame marker, then top dark rows
    fill_rand(4096); send_line(LINE, 0, 0); hold_chk("R6 pre-frame", 0);
    fill_rand(4096); send_line(LINE, 1, 0); hold_chk("R6 top row0", 0);
    fill_rand(4096); send_line(LINE, 0, 1); hold_chk("R6 top row1", 0);
    // R3: empty/outer columns full scale, usable columns fixed
    avg_mode = 2'b00; fill_dir(100, 200, 4095); send_line(LINE, 0, 0);
    chk(black_level == 148, "R3 exclusion", int'(black_level), 148);
    avg_mode = 2'b01; fill_rand(4096); send_line(LINE, 0, 0);
    avg_mode = 2'b10; fill_rand(4096); send_line(LINE, 0, 1);
    saved = exp_level;
    fill_dir(0, 0, 0); send_line(LINE, 0, 0); hold_chk("R6 bottom row", saved);
    // new frame: R7 truncated line, R10 full scale, R2 gaps
    fill_rand(4096); send_line(LINE, 1, 1);
    fill_rand(4096); send_line(LINE, 0, 0);
    fill_dir(10, 10, 0); send_line(TR_HI - 2, 0, 1); hold_chk("R7 truncated", saved);
    avg_mode = 2'b11; fill_dir(4095, 4095, 0); send_line(LINE, 0, 0);
    chk(black_level == 4095, "R10 full scale", int'(black_level), 4095);
    avg_mode = 2'b01; fill_dir(4095, 0, 0); send_line(LINE, 0, 1);
    chk(black_level == 4095, "R4 lead only", int'(black_level), 4095);
    // random frames with gaps and modes (R2, R4, R8)
    for (int f = 0; f < 4; f++)
      for (int r = 0; r < TOP + ROWS + BOT; r++) begin
        avg_mode = 2'($urandom % 4);
        fill_rand((r % 2) ? 4096 : 600);
        send_line(LINE, r == 0, 1);
      end
    drive(0, 0, 0, 0);
    chk(exp_level != 0, "R2 model live", exp_level, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule